// File: doc/BRIEF.md
# Fast page mode DRAM sequencer

This block connects a synchronous request port to an asynchronous fast page mode DRAM array. Each request carries a read/write flag, a 20-bit word address and a data word. The block splits the address into a row and a column and places them one after the other on a 10-bit multiplexed address bus. It generates the active-low row strobe, column strobe, write enable and output enable. While requests keep hitting the open row, it leaves the row strobe low and issues one column cycle after another. Read data comes back on a one-cycle valid pulse, in request order. Writes always use early-write timing.

Every analog limit is given in nanoseconds as a parameter. Each one becomes a clock-cycle count, rounded up for the clock period (10 ns by default). The sequencer waits out each count before it moves on. The block does not refresh the array itself. Between accesses, it hands the bus to an external refresh unit through a request/grant/done handshake, and only after the open row has been precharged.

Top module: `fpm_dram_seq`

## Requirements
- R1: While reset is held, ras_n, cas_n, we_n and oe_n are all high, dq_oe, rd_valid and ref_gnt are low. After reset is released with no refresh pending, req_ready is high.
- R2: The row, req_addr[19:10], is on dram_addr while RAS falls. The column, req_addr[9:0], is on dram_addr while CAS falls. CAS falls no sooner than 2 cycles after RAS falls.
- R3: Before each RAS fall, RAS has been high for at least 5 cycles. This is the larger of the 40 ns precharge and the 110 ns cycle time less the 60 ns minimum low time. CAS is also high in the cycle before RAS falls.
- R4: Every RAS low period lasts at least 6 cycles and at most 1000 cycles.
- R5: A read column cycle drives oe_n low. CAS stays low for 5 cycles on the first column after RAS falls, which covers the 65 ns access from RAS. On a page hit CAS stays low for 4 cycles, which covers the 35 ns column-address access. Data is sampled on the edge where CAS rises. It is returned once with a one-cycle rd_valid pulse, in request order.
- R6: A write column cycle is an early write. we_n is low no later than the CAS falling edge, dq_oe drives the write data, oe_n stays high and CAS is low for 2 cycles. No rd_valid results.
- R7: A request to the open row is taken after a 1-cycle CAS precharge and served by a CAS-only cycle, with RAS held low. CAS is high for at least one cycle between column cycles.
- R8: A request to a different row closes the open row. RAS rises, the row is precharged, and a new RAS cycle opens the new row.
- R9: When no request is waiting after a column cycle, RAS rises as soon as its minimum low time is met.
- R10: During an unbroken stream of page hits, the row is closed before the low-time limit in R4, and the next hit reopens it with a new RAS cycle.
- R11: ref_gnt rises only after RAS has been high at least 5 cycles. It stays high with RAS and CAS high until ref_done is seen, then falls on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 100 MHz nominal |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The request is taken at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address: row in the upper half, column in the lower half |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds read data |
| rd_data | output | 16 | Read data |
| ref_req | input | 1 | The refresh unit asks for the bus |
| ref_gnt | output | 1 | The bus is handed to the refresh unit |
| ref_done | input | 1 | The refresh unit returns the bus |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_oe | output | 1 | Enables the write data drivers |
| dram_dq_out | output | 16 | Write data to the array |
| dram_dq_in | input | 16 | Read data from the array |

## Verification
The bench runs several request patterns. An isolated read followed by idle time shows whether the row is closed when work runs out. A mixed read/write run in one row shows whether page hits are kept under one RAS period, and checks that the first column gets the longer access time while hits get the shorter one. Alternating rows, including a write to a new row, show whether misses really close and reopen the row. A 260-read stream in one row reaches the RAS low-time guard. A refresh request raised while a row is still open shows whether the grant waits for a full precharge. A behavioural array model in the bench returns data, so the scoreboard's in-order data comparison also confirms the row and column mapping.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    // Sequencer states: the row strobe is low in ST_ACT, ST_COL and ST_CPRE
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACT,
        ST_COL,
        ST_CPRE,
        ST_PRE,
        ST_REF
    } fpm_state_e;

    // Converts a time limit in ns to whole clock cycles, rounding up
    function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
        return (t_ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpm_wait_timer.sv
// Shared down-counter for every state dwell of the sequencer.
// Assumes: load is pulsed on the edge a state is entered and
// load_val >= 1; done is high once load_val cycles have elapsed.
module fpm_wait_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    // Reload on state entry, otherwise count down to zero and hold
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val - 1'b1;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // A zero dwell would wrap the counter and break every state limit (R2)
    a_r2_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

endmodule

// File: rtl/fpm_ras_window.sv
// Measures how long the row strobe has been low.
// Assumes: ras_low is the registered row-strobe state. min_met says
// RAS may rise at the next edge; near_max says no further column
// cycle fits before the upper limit (GUARD covers the longest one).
module fpm_ras_window #(
    parameter int MIN_CYC = 6,
    parameter int MAX_CYC = 1000,
    parameter int GUARD   = 7,
    parameter int CW      = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_low,
    output logic          min_met,
    output logic          near_max,
    output logic [CW-1:0] lo_cnt
);
    // Cycles spent low before the current one, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || !ras_low)           lo_cnt <= '0;
        else if (lo_cnt != CW'(MAX_CYC))  lo_cnt <= lo_cnt + 1'b1;
    end

    assign min_met  = (lo_cnt >= CW'(MIN_CYC - 1));
    assign near_max = (lo_cnt >= CW'(MAX_CYC - GUARD));

    a_r4_ras_max: assert property (@(posedge clk) disable iff (!rst_n)
        ras_low |-> (lo_cnt < CW'(MAX_CYC)));

    a_r4_ras_min: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_low && $past(ras_low)) |-> ($past(lo_cnt) >= CW'(MIN_CYC - 1)));

endmodule

// File: rtl/fpm_row_track.sv
// Holds the open row and compares it with the incoming request.
// Assumes: open_en is high only when a new row is being activated.
module fpm_row_track #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_en,
    input  logic [ROW_W-1:0] row_in,
    output logic [ROW_W-1:0] open_row,
    output logic             hit
);
    // Capture the row that is about to be strobed
    always_ff @(posedge clk) begin
        if (!rst_n)       open_row <= '0;
        else if (open_en) open_row <= row_in;
    end

    assign hit = (row_in == open_row);

endmodule

// File: rtl/fpm_dram_seq.sv
// Fast page mode DRAM sequencer: turns a request stream into RAS/CAS
// cycles, keeps the row open while hits continue, and hands the bus to an
// external refresh unit between accesses.
// Assumes: ADDR_W == 2*BUS_W; the array has been idle with RAS high for
// at least the precharge time when reset is released; strobes are taken
// straight from registered state, so they change only at clock edges.
module fpm_dram_seq
    import fpm_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter int BUS_W        = 10,
    parameter int DATA_W       = 16,
    parameter int CLK_NS       = 10,
    parameter int T_RCD_NS     = 20,
    parameter int T_RP_NS      = 40,
    parameter int T_RC_NS      = 110,
    parameter int T_RASMIN_NS  = 60,
    parameter int T_RASMAX_NS  = 10000,
    parameter int T_RAC_NS     = 65,
    parameter int T_CAC_NS     = 20,
    parameter int T_AA_NS      = 35,
    parameter int T_CAS_NS     = 10,
    parameter int T_CP_NS      = 10,
    parameter int T_CAH_NS     = 15,
    parameter int T_DH_NS      = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ref_req,
    output logic              ref_gnt,
    input  logic              ref_done,
    output logic [BUS_W-1:0]  dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic              dram_dq_oe,
    output logic [DATA_W-1:0] dram_dq_out,
    input  logic [DATA_W-1:0] dram_dq_in
);
    localparam int ROW_W      = ADDR_W - BUS_W;
    localparam int RCD_CYC    = ns_to_cyc(T_RCD_NS, CLK_NS);
    localparam int RASMIN_CYC = ns_to_cyc(T_RASMIN_NS, CLK_NS);
    localparam int RASMAX_CYC = ns_to_cyc(T_RASMAX_NS, CLK_NS);
    localparam int PRE_CYC    = imax(ns_to_cyc(T_RP_NS, CLK_NS),
                                     ns_to_cyc(T_RC_NS, CLK_NS) - RASMIN_CYC);
    localparam int ACC_CYC    = imax(ns_to_cyc(T_CAC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS));
    localparam int ACC1_CYC   = imax(ACC_CYC, ns_to_cyc(T_RAC_NS, CLK_NS) - RCD_CYC);
    localparam int WR_CYC     = imax(ns_to_cyc(T_CAS_NS, CLK_NS),
                                     imax(ns_to_cyc(T_CAH_NS, CLK_NS), ns_to_cyc(T_DH_NS, CLK_NS)));
    localparam int CP_CYC     = ns_to_cyc(T_CP_NS, CLK_NS);
    localparam int GUARD_CYC  = imax(ACC_CYC, WR_CYC) + CP_CYC + 2;
    localparam int TMAX       = imax(imax(RCD_CYC, PRE_CYC), imax(imax(ACC1_CYC, WR_CYC), CP_CYC));
    localparam int TW         = $clog2(TMAX + 1);
    localparam int CW         = $clog2(RASMAX_CYC + 1);
    localparam int HW         = $clog2(PRE_CYC + 1);

    fpm_state_e        state_q, state_d;
    logic [BUS_W-1:0]  col_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;
    logic              accept, col_we, ras_low;
    logic              tmr_load, tmr_done;
    logic [TW-1:0]     tmr_val;
    logic              min_met, near_max, row_hit;
    logic [CW-1:0]     lo_cnt;
    logic [ROW_W-1:0]  open_row;

    // Take a request when idle and precharged, or on a hit at the end of CAS precharge
    assign req_ready = (state_q == ST_IDLE && !ref_req) ||
                       (state_q == ST_CPRE && tmr_done && row_hit && !near_max);
    assign accept    = req_valid && req_ready;
    assign ras_low   = (state_q == ST_ACT) || (state_q == ST_COL) || (state_q == ST_CPRE);
    assign col_we    = (state_q == ST_CPRE) ? req_write : we_q;

    // Next-state choice: each dwell ends on tmr_done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ref_req)        state_d = ST_REF;
                     else if (req_valid) state_d = ST_ACT;
            ST_ACT:  if (tmr_done)       state_d = ST_COL;
            ST_COL:  if (tmr_done)       state_d = ST_CPRE;
            ST_CPRE: if (tmr_done) begin
                         if (accept)       state_d = ST_COL;
                         else if (min_met) state_d = ST_PRE;
                     end
            ST_PRE:  if (tmr_done)       state_d = ST_IDLE;
            ST_REF:  if (ref_done)       state_d = ST_PRE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    // Dwell length of the state being entered
    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            ST_ACT:  tmr_val = TW'(RCD_CYC);
            ST_COL:  tmr_val = col_we ? TW'(WR_CYC)
                             : ((state_q == ST_ACT) ? TW'(ACC1_CYC) : TW'(ACC_CYC));
            ST_CPRE: tmr_val = TW'(CP_CYC);
            ST_PRE:  tmr_val = TW'(PRE_CYC);
            default: tmr_val = TW'(1);
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture column, direction and write data of each accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q   <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else if (accept) begin
            col_q   <= req_addr[BUS_W-1:0];
            we_q    <= req_write;
            wdata_q <= req_wdata;
        end
    end

    // Sample read data on the edge that ends a read column cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (state_q == ST_COL) && tmr_done && !we_q;
            if ((state_q == ST_COL) && tmr_done && !we_q) rd_data <= dram_dq_in;
        end
    end

    fpm_wait_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    fpm_ras_window #(.MIN_CYC(RASMIN_CYC), .MAX_CYC(RASMAX_CYC), .GUARD(GUARD_CYC), .CW(CW)) u_ras_win (
        .clk(clk), .rst_n(rst_n), .ras_low(ras_low),
        .min_met(min_met), .near_max(near_max), .lo_cnt(lo_cnt)
    );

    fpm_row_track #(.ROW_W(ROW_W)) u_row (
        .clk(clk), .rst_n(rst_n), .open_en(accept && state_q == ST_IDLE),
        .row_in(req_addr[ADDR_W-1:BUS_W]), .open_row(open_row), .hit(row_hit)
    );

    // DRAM pins follow the registered state
    assign dram_ras_n  = !ras_low;
    assign dram_cas_n  = (state_q != ST_COL);
    assign dram_addr   = (state_q == ST_ACT) ? open_row : col_q;
    assign dram_we_n   = !(we_q && ras_low);
    assign dram_oe_n   = !((state_q == ST_COL) && !we_q);
    assign dram_dq_oe  = (state_q == ST_COL) && we_q;
    assign dram_dq_out = wdata_q;
    assign ref_gnt     = (state_q == ST_REF);

    // Checker: cycles RAS has been high, starting precharged after reset
    logic [HW-1:0] hi_age;
    always_ff @(posedge clk) begin
        if (!rst_n)                        hi_age <= HW'(PRE_CYC);
        else if (!dram_ras_n)              hi_age <= '0;
        else if (hi_age != HW'(PRE_CYC))   hi_age <= hi_age + 1'b1;
    end

    a_r3_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (hi_age >= HW'(PRE_CYC)));

    a_r3_cas_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> $past(dram_cas_n));

    a_r2_ras_to_cas: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> (lo_cnt >= CW'(RCD_CYC)));

    a_r6_drive_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> (!dram_we_n && dram_oe_n && !dram_cas_n));

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r11_grant_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        ref_gnt |-> (dram_ras_n && dram_cas_n));

endmodule

// File: tb/tb_fpm_dram_seq.sv
module tb_fpm_dram_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_write;
    logic [19:0] req_addr;
    logic [15:0] req_wdata;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        ref_req, ref_gnt, ref_done;
    logic [9:0]  dram_addr;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [15:0] dram_dq_out, dram_dq_in;

    always #2 clk = ~clk;

    fpm_dram_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_gnt(ref_gnt),
        .ref_done(ref_done), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_dq_oe(dram_dq_oe), .dram_dq_out(dram_dq_out), .dram_dq_in(dram_dq_in)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] dram_mem [256];
    logic [15:0] exp_mem  [256];
    logic [15:0] exp_q [$];
    logic [9:0]  row_lat = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Array model: read data appears while CAS and OE are low
    always_comb dram_dq_in = (!dram_cas_n && !dram_oe_n) ?
                             dram_mem[{row_lat[3:0], dram_addr[3:0]}] : 16'h0;

    // Timing monitor, array model writes and scoreboard, away from the active edge
    bit p_ras = 1'b1, p_cas = 1'b1, p_gnt = 1'b0, col_first = 1'b0, col_we = 1'b0;
    int ras_lo = 0, ras_hi = 100, cas_lo = 0, cas_hi = 100, n_ras_fall = 0, cyc = 0;
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            check(1'b0, "watchdog", "cycles", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
        if (rst_n) begin
            if (p_ras && !dram_ras_n) begin
                check(ras_hi >= 5, "R3", "RAS high cycles before fall", ras_hi, 5);
                check(p_cas == 1'b1, "R3", "CAS high before RAS fall", int'(p_cas), 1);
                row_lat = dram_addr;
                n_ras_fall++;
            end
            if (!p_ras && dram_ras_n)
                check(ras_lo >= 6 && ras_lo <= 1000, "R4", "RAS low cycles", ras_lo, 6);
            if (p_cas && !dram_cas_n) begin
                check(ras_lo >= 2, "R2", "RAS to CAS cycles", ras_lo, 2);
                check(cas_hi >= 1, "R7", "CAS precharge cycles", cas_hi, 1);
                col_first = (ras_lo == 2);
                col_we    = !dram_we_n;
                if (!dram_we_n) begin
                    check(dram_dq_oe && dram_oe_n, "R6", "early write drive/oe",
                          int'(dram_dq_oe && dram_oe_n), 1);
                    dram_mem[{row_lat[3:0], dram_addr[3:0]}] = dram_dq_out;
                end else begin
                    check(!dram_oe_n, "R5", "oe_n low on read", int'(dram_oe_n), 0);
                end
            end
            if (!p_cas && dram_cas_n) begin
                if (col_we) check(cas_lo == 2, "R6", "write CAS low cycles", cas_lo, 2);
                else        check(cas_lo == (col_first ? 5 : 4), "R5", "read CAS low cycles",
                                  cas_lo, col_first ? 5 : 4);
            end
            if (rd_valid) begin
                if (exp_q.size() == 0) check(1'b0, "R5", "unexpected rd_valid", 1, 0);
                else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check(rd_data == e, "R5", "read data", int'(rd_data), int'(e));
                end
            end
            if (ref_gnt)
                check(dram_ras_n && dram_cas_n, "R11", "strobes high while granted",
                      int'(dram_ras_n && dram_cas_n), 1);
            if (ref_gnt && !p_gnt)
                check(ras_hi >= 5, "R11", "precharge before grant", ras_hi, 5);
        end
        if (dram_ras_n) begin ras_hi++; ras_lo = 0; end else begin ras_lo++; ras_hi = 0; end
        if (dram_cas_n) begin cas_hi++; cas_lo = 0; end else begin cas_lo++; cas_hi = 0; end
        p_ras = dram_ras_n;
        p_cas = dram_cas_n;
        p_gnt = ref_gnt;
    end

    // Driver: offer one request, record the expected result, return after acceptance
    task automatic issue(input bit wr, input int row, input int col, input logic [15:0] d);
        logic [7:0] idx;
        idx       = {row[3:0], col[3:0]};
        req_write = wr;
        req_addr  = {10'(row), 10'(col)};
        req_wdata = d;
        req_valid = 1'b1;
        if (wr) exp_mem[idx] = d;
        else    exp_q.push_back(exp_mem[idx]);
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    int f0;
    initial begin
        for (int i = 0; i < 256; i++) begin
            dram_mem[i] = 16'(i * 613 + 29);
            exp_mem[i]  = 16'(i * 613 + 29);
        end
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        ref_req = 1'b0; ref_done = 1'b0;
        idle(3);
        // R1: reset state
        check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1", "strobes high",
              int'(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n), 1);
        check(!dram_dq_oe && !rd_valid && !ref_gnt, "R1", "outputs idle",
              int'(dram_dq_oe || rd_valid || ref_gnt), 0);
        rst_n = 1'b1;
        idle(1);
        check(req_ready, "R1", "ready after reset", int'(req_ready), 1);

        // R9: single read then idle closes the row
        f0 = n_ras_fall;
        issue(1'b0, 1, 3, '0);
        idle(30);
        check(n_ras_fall - f0 == 1, "R9", "RAS cycles for lone read", n_ras_fall - f0, 1);
        check(dram_ras_n, "R9", "row closed when idle", int'(dram_ras_n), 1);

        // R7: hits in one row, mixed writes and reads, one RAS period
        f0 = n_ras_fall;
        issue(1'b1, 2, 1, 16'h1111);
        issue(1'b1, 2, 2, 16'h2222);
        issue(1'b0, 2, 1, '0);
        issue(1'b0, 2, 2, '0);
        issue(1'b0, 2, 7, '0);
        idle(30);
        check(n_ras_fall - f0 == 1, "R7", "RAS cycles for page hits", n_ras_fall - f0, 1);

        // R8: row misses close and reopen
        f0 = n_ras_fall;
        issue(1'b0, 3, 4, '0);
        issue(1'b0, 5, 4, '0);
        issue(1'b1, 6, 4, 16'h3C3C);
        issue(1'b0, 6, 4, '0);
        issue(1'b0, 3, 4, '0);
        idle(30);
        check(n_ras_fall - f0 == 4, "R8", "RAS cycles for misses", n_ras_fall - f0, 4);

        // R10: long hit stream crosses the RAS low-time guard
        f0 = n_ras_fall;
        for (int i = 0; i < 260; i++) issue(1'b0, 9, i % 16, '0);
        idle(30);
        check(n_ras_fall - f0 >= 2, "R10", "row reopened in long stream", n_ras_fall - f0, 2);

        // R11: refresh asked while a row is open
        issue(1'b0, 1, 1, '0);
        ref_req = 1'b1;
        for (int i = 0; i < 40 && !ref_gnt; i++) @(negedge clk);
        check(ref_gnt, "R11", "grant given", int'(ref_gnt), 1);
        idle(4);
        check(ref_gnt, "R11", "grant held until done", int'(ref_gnt), 1);
        ref_done = 1'b1;
        @(negedge clk);
        ref_done = 1'b0;
        ref_req  = 1'b0;
        check(!ref_gnt, "R11", "grant dropped after done", int'(ref_gnt), 0);
        issue(1'b0, 1, 1, '0);
        idle(30);
        check(exp_q.size() == 0, "R5", "all reads returned", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule